// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock for an SD card from a faster base clock. Two dividers sit in series: a prescaler restricted to powers of two between 2 and 256, and a linear divisor between 1 and 16. Their product sets the card clock period in base cycles. The output is a registered, toggling card clock together with a one-cycle pulse that marks each rising edge of that clock. A host that only needs a clock enable can use the pulse instead of the clock.

The division setting can only be changed while the clock is switched off. A write made while the clock runs is dropped, so the running clock is never disturbed. A stable flag tells the host when a full period has run at the current setting. A card-initialisation sequence counts a fixed number of card clock cycles and then reports completion. If the cycles fail to arrive within a set time, it reports failure instead.

Top module: `sd_clkgen`

## Requirements
- R1: The prescale code `k` (3 bits) selects a prescale of 2^(k+1), giving 2 to 256. The divisor code `d` (4 bits) selects a divisor of d+1, giving 1 to 16. One card clock period lasts 2^(k+1)*(d+1) base cycles.
- R2: The total division is always even. The card clock is high for exactly half of the period and low for the other half.
- R3: The card clock goes high at the first base clock edge where the enable is sampled high, and that first high phase has full length. The edge after the enable is sampled low drives the card clock low, and the divider state is cleared.
- R4: `clk_pulse` is high for exactly the first base cycle of every high phase of the card clock, and low at all other times.
- R5: A settings write is accepted only on an edge where the enable is low. A write while the enable is high changes neither the period nor the stable flag.
- R6: `clk_stable` is low while disabled. After an enable it stays low until the second rising edge of the card clock, which closes one full period, and it goes high on that edge.
- R7: An init strobe clears any earlier done or failure result. `init_done` goes high one base cycle after the 80th `clk_pulse` that follows the strobe.
- R8: If 80 pulses have not arrived within `TIMEOUT_CYC` base cycles after the strobe, `init_fail` goes high on exactly that cycle and `init_done` stays low.
- R9: During and after reset all outputs are low, and the settings hold their reset values. These default to prescale code 7 and divisor code 0, a half period of 128 base cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Card clock enable |
| cfg_we | input | 1 | Settings write strobe |
| cfg_pre_code | input | 3 | Prescale code k, prescale 2^(k+1) |
| cfg_div_code | input | 4 | Divisor code d, divisor d+1 |
| init_start | input | 1 | Start the 80-cycle initialisation burst |
| card_clk | output | 1 | Divided card clock |
| clk_pulse | output | 1 | One-cycle marker of each card clock rising edge |
| clk_stable | output | 1 | Card clock has run one full period at current setting |
| init_done | output | 1 | Initialisation burst completed |
| init_fail | output | 1 | Initialisation burst timed out |

## Verification
The card clock and its pulse respond at the first edge that samples the enable: both are high in the base cycle right after the enable rises. Each phase then lasts 2^k*(d+1) cycles. The stable flag is due on the edge of the second rise. `init_done` follows the 80th pulse by one cycle, and `init_fail` appears `TIMEOUT_CYC` edges after the strobe edge. The bench drives inputs and samples outputs on falling edges. It counts samples per phase and per event rather than waiting on outputs, so a result that arrives one cycle early or late changes a count and is caught.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the SD card clock generator.
// Assumes: code widths are fixed by the card clock range (2..256, 1..16).
package sdclk_pkg;
    localparam int PRE_CODE_W  = 3;
    localparam int DIV_CODE_W  = 4;
    localparam int INIT_CLOCKS = 80;

    typedef enum logic [1:0] {
        INIT_IDLE    = 2'd0,
        INIT_RUN     = 2'd1,
        INIT_OK      = 2'd2,
        INIT_TIMEOUT = 2'd3
    } sdclk_init_e;
endpackage

// File: rtl/sdclk_prescale.sv
`timescale 1ns/1ps
// Power-of-two prescale stage: emits one tick every 2^code base cycles while
// run is high. Together with the toggling stage this gives a prescale of
// 2^(code+1). Assumes: code is held steady while run is high.
module sdclk_prescale #(
    parameter int CODE_W = sdclk_pkg::PRE_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;

    // Thermometer decode of the code into the terminal count 2^code - 1.
    for (genvar i = 0; i < CNT_W; i++) begin : g_limit
        assign limit[i] = (32'(code) > i);
    end

    assign tick = run && (cnt_q == limit);

    // Count base cycles, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sdclk_divide.sv
`timescale 1ns/1ps
// Linear divisor and output stage: counts prescaler ticks and toggles the
// card clock every (div_code+1) ticks. Starts with a full high phase on
// enable, marks each rising edge with a pulse and raises the stable flag on
// the second rising edge. Assumes: settings are steady while en is high.
module sdclk_divide #(
    parameter int PRE_W = sdclk_pkg::PRE_CODE_W,
    parameter int DIV_W = sdclk_pkg::DIV_CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre_code,
    input  logic [DIV_W-1:0] div_code,
    output logic             running,
    output logic             card_clk,
    output logic             clk_pulse,
    output logic             clk_stable
);
    localparam int HALF_W = (1 << PRE_W) - 1 + DIV_W + 1;

    logic [DIV_W-1:0] dcnt_q;
    logic             toggle;

    assign toggle = running && tick && (dcnt_q == div_code);

    // Start, divide and toggle the card clock; track the stable flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running    <= 1'b0;
            card_clk   <= 1'b0;
            clk_pulse  <= 1'b0;
            clk_stable <= 1'b0;
            dcnt_q     <= '0;
        end else if (!running) begin
            running   <= 1'b1;
            card_clk  <= 1'b1;
            clk_pulse <= 1'b1;
            dcnt_q    <= '0;
        end else begin
            clk_pulse <= 1'b0;
            if (toggle) begin
                dcnt_q   <= '0;
                card_clk <= ~card_clk;
                if (!card_clk) begin
                    clk_pulse  <= 1'b1;
                    clk_stable <= 1'b1;
                end
            end else if (tick) begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    // Checker: each phase must last 2^pre_code*(div_code+1) base cycles.
    logic [HALF_W-1:0] half_len;
    logic [HALF_W-1:0] chk_gap_q;
    assign half_len = (HALF_W'(1) << pre_code) * HALF_W'({1'b0, div_code} + 1'b1);

    // Count cycles since the last card clock edge and compare at each toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !running) begin
            chk_gap_q <= '0;
        end else if (toggle) begin
            a_r2_half_phase: assert (chk_gap_q == half_len - 1'b1)
                else $error("R2 phase length %0d, expected %0d", chk_gap_q + 1'b1, half_len);
            chk_gap_q <= '0;
        end else begin
            chk_gap_q <= chk_gap_q + 1'b1;
        end
    end

    a_r3_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !card_clk);
    a_r6_stable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_stable);
    a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        clk_pulse |-> $rose(card_clk));
    a_r6_stable_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_stable) |-> card_clk && $past(running));
endmodule

// File: rtl/sdclk_initseq.sv
`timescale 1ns/1ps
// Card initialisation sequencer: after a start strobe, counts card clock
// rising-edge pulses; reports done at INIT_CLOCKS pulses or failure after
// TIMEOUT_CYC base cycles. Assumes: clk_pulse is one base cycle wide.
module sdclk_initseq #(
    parameter int INIT_CLOCKS = sdclk_pkg::INIT_CLOCKS,
    parameter int TIMEOUT_CYC = 655360
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clk_pulse,
    output logic init_done,
    output logic init_fail
);
    import sdclk_pkg::*;

    localparam int CW = $clog2(INIT_CLOCKS) + 1;
    localparam int TW = $clog2(TIMEOUT_CYC) + 1;

    sdclk_init_e   state_q;
    logic [CW-1:0] cnt_q;
    logic [TW-1:0] tcnt_q;

    // Sequence the burst: count pulses, watch the timeout, latch the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= INIT_IDLE;
            cnt_q   <= '0;
            tcnt_q  <= '0;
        end else if (start) begin
            state_q <= INIT_RUN;
            cnt_q   <= '0;
            tcnt_q  <= '0;
        end else if (state_q == INIT_RUN) begin
            if (clk_pulse && (cnt_q == CW'(INIT_CLOCKS - 1))) begin
                state_q <= INIT_OK;
            end else if (tcnt_q == TW'(TIMEOUT_CYC - 1)) begin
                state_q <= INIT_TIMEOUT;
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
                if (clk_pulse) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign init_done = (state_q == INIT_OK);
    assign init_fail = (state_q == INIT_TIMEOUT);

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(clk_pulse) && ($past(cnt_q) == CW'(INIT_CLOCKS - 1)));
    a_r8_fail_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_fail) |-> ($past(tcnt_q) == TW'(TIMEOUT_CYC - 1)) && !init_done);
    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !init_done && !init_fail);
endmodule

// File: rtl/sd_clkgen.sv
`timescale 1ns/1ps
// SD card clock generator top: holds the division settings (writable only
// while the clock is off), chains the prescale and divide stages and runs
// the initialisation sequencer on the rising-edge pulses.
// Assumes: all inputs are synchronous to clk.
module sd_clkgen #(
    parameter int PRE_W        = sdclk_pkg::PRE_CODE_W,
    parameter int DIV_W        = sdclk_pkg::DIV_CODE_W,
    parameter int RST_PRE_CODE = 7,
    parameter int RST_DIV_CODE = 0,
    parameter int INIT_CLOCKS  = sdclk_pkg::INIT_CLOCKS,
    parameter int TIMEOUT_CYC  = 655360
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cfg_we,
    input  logic [PRE_W-1:0] cfg_pre_code,
    input  logic [DIV_W-1:0] cfg_div_code,
    input  logic             init_start,
    output logic             card_clk,
    output logic             clk_pulse,
    output logic             clk_stable,
    output logic             init_done,
    output logic             init_fail
);
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] div_q;
    logic             running;
    logic             tick;

    // Latch new settings only while the card clock is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= PRE_W'(RST_PRE_CODE);
            div_q <= DIV_W'(RST_DIV_CODE);
        end else if (cfg_we && !clk_en) begin
            pre_q <= cfg_pre_code;
            div_q <= cfg_div_code;
        end
    end

    sdclk_prescale #(.CODE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .code  (pre_q),
        .tick  (tick)
    );

    sdclk_divide #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (clk_en),
        .tick       (tick),
        .pre_code   (pre_q),
        .div_code   (div_q),
        .running    (running),
        .card_clk   (card_clk),
        .clk_pulse  (clk_pulse),
        .clk_stable (clk_stable)
    );

    sdclk_initseq #(.INIT_CLOCKS(INIT_CLOCKS), .TIMEOUT_CYC(TIMEOUT_CYC)) u_init (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (init_start),
        .clk_pulse (clk_pulse),
        .init_done (init_done),
        .init_fail (init_fail)
    );

    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && $past(clk_en) |-> $stable(pre_q) && $stable(div_q));
    a_r9_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !clk_pulse && !card_clk);
endmodule

// File: tb/tb_sd_clkgen.sv
`timescale 1ns/1ps
// Self-checking bench: table of settings with expected half periods, then
// directed tests for reset, ignored writes, disable, init burst and timeout.
module tb_sd_clkgen;
    localparam int TO = 400;
    localparam int NV = 8;
    localparam int V_PRE  [NV] = '{0, 0, 1, 2, 4, 3, 7, 7};
    localparam int V_DIV  [NV] = '{0, 1, 2, 4, 6, 15, 0, 15};
    localparam int V_HALF [NV] = '{1, 2, 6, 20, 112, 128, 128, 2048};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_pre_code = '0;
    logic [3:0] cfg_div_code = '0;
    logic       init_start = 1'b0;
    logic       card_clk, clk_pulse, clk_stable, init_done, init_fail;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sd_clkgen #(.TIMEOUT_CYC(TO)) dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we),
        .cfg_pre_code(cfg_pre_code), .cfg_div_code(cfg_div_code),
        .init_start(init_start), .card_clk(card_clk), .clk_pulse(clk_pulse),
        .clk_stable(clk_stable), .init_done(init_done), .init_fail(init_fail)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int p, input int d);
        @(negedge clk);
        clk_en = 1'b0; cfg_we = 1'b1;
        cfg_pre_code = 3'(p); cfg_div_code = 4'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Raise enable; the following sample is the first high cycle (R3).
    task automatic start_clk();
        clk_en = 1'b1;
        @(negedge clk);
        chk("R3 first edge high", int'(card_clk), 1);
    endtask

    // Measure one full period from the next rising-edge pulse.
    task automatic measure(input int exp_half, input bit fresh, input string req);
        int guard = 0;
        int hi = 0;
        int lo = 0;
        int pul = 0;
        int bad = 0;
        while (!clk_pulse && guard < 10000) begin
            @(negedge clk); guard++;
        end
        chk({req, " pulse at rise"}, int'(clk_pulse && card_clk), 1);
        while (card_clk && hi < 5000) begin
            hi++; if (clk_pulse) pul++;
            if (clk_stable == fresh) bad++;
            @(negedge clk);
        end
        while (!card_clk && lo < 5000) begin
            lo++; if (clk_pulse) pul++;
            if (clk_stable == fresh) bad++;
            @(negedge clk);
        end
        chk({req, " R1 period"}, hi + lo, 2 * exp_half);
        chk({req, " R2 high phase"}, hi, exp_half);
        chk({req, " R2 low phase"}, lo, exp_half);
        chk({req, " R4 one pulse per period"}, pul, 1);
        chk({req, " R6 stable during period"}, bad, 0);
        chk({req, " R6 stable after period"}, int'(clk_stable), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 clk in reset", int'(card_clk), 0);
        chk("R9 stable in reset", int'(clk_stable), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 outputs after reset",
            int'({card_clk, clk_pulse, clk_stable, init_done, init_fail}), 0);
        // R9: default setting gives half period 128
        start_clk();
        measure(128, 1'b1, "R9 default");

        // Table walk: R1, R2, R4, R6
        for (int v = 0; v < NV; v++) begin
            set_cfg(V_PRE[v], V_DIV[v]);
            start_clk();
            measure(V_HALF[v], 1'b1, "R1 table");
        end

        // R5: write while enabled is ignored
        set_cfg(0, 0);
        start_clk();
        measure(1, 1'b1, "R5 setup");
        @(negedge clk);
        cfg_we = 1'b1; cfg_pre_code = 3'd7; cfg_div_code = 4'd15;
        @(negedge clk);
        cfg_we = 1'b0;
        measure(1, 1'b0, "R5 running");
        clk_en = 1'b0;
        @(negedge clk);
        start_clk();
        measure(1, 1'b1, "R5 after re-enable");

        // R3: disable mid high phase, then full high phase on re-enable
        set_cfg(2, 4);
        start_clk();
        repeat (5) @(negedge clk);
        chk("R3 high before disable", int'(card_clk), 1);
        clk_en = 1'b0;
        @(negedge clk);
        chk("R3 low after disable", int'(card_clk), 0);
        chk("R6 stable low after disable", int'(clk_stable), 0);
        repeat (3) @(negedge clk);
        chk("R3 stays low", int'(card_clk | clk_pulse), 0);
        start_clk();
        measure(20, 1'b1, "R3 restart");

        // R7: init burst of 80 pulses at half period 2
        set_cfg(0, 1);
        start_clk();
        measure(2, 1'b1, "R7 setup");
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        begin
            int pcount = 0;
            int guard = 0;
            while (!init_done && guard < 1000) begin
                if (clk_pulse) pcount++;
                guard++;
                @(negedge clk);
            end
            chk("R7 done raised", int'(init_done), 1);
            chk("R7 pulses before done", pcount, 80);
            chk("R7 no fail", int'(init_fail), 0);
        end

        // R8: timeout with the clock disabled; strobe also clears done (R7)
        clk_en = 1'b0;
        init_start = 1'b1;
        @(negedge clk);
        init_start = 1'b0;
        chk("R7 start clears done", int'(init_done), 0);
        for (int i = 0; i <= TO; i++) begin
            if (i == TO - 1) chk("R8 no fail before limit", int'(init_fail), 0);
            if (i == TO) chk("R8 fail at limit", int'(init_fail), 1);
            if (i < TO) @(negedge clk);
        end
        chk("R8 done stays low", int'(init_done), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule